// File: doc/BRIEF.md
# Per-Byte Rotating Field Extractor

The block takes a wide operand made of independent 64-bit words and a second operand of the same width that holds eight control bytes for each word. Each control byte picks its own 8-bit window from its word: the word is rotated right by the control's low six bits, and the low byte of the rotated value becomes one output byte. The windows are bit-granular and wrap around the top of the word. Each output byte chooses its window on its own, so no single shift amount applies to a whole word.

The typical use is unpacking 6-bit fields from packed bytes for a base64 encoder. In that case the control bytes hold offsets 0, 6, 12, 18 and so on, and a later stage masks the top two bits of each output byte. The datapath has one register stage. An operand pair is accepted in every cycle in which the input valid is high, and its result appears one cycle later. While the input valid is low, the previous result is held.

Top module: `rot_field_extract`

## Requirements
- R1: While rst_ni is low, and after its release until the first valid input, valid_o is 0 and result_o is all zeros.
- R2: valid_o equals the valid_i of the previous clock edge, giving a latency of exactly one cycle.
- R3: Output bit b of byte j of lane k (result_o bit 64k+8j+b) equals data_i bit 64k+((s+b) mod 64). Here s is bits [5:0] of control byte j of lane k, which is ctrl_i bits [64k+8j+5 : 64k+8j].
- R4: Bits [7:6] of every control byte have no effect on the result.
- R5: Windows that start at 57..63 wrap around the word: their low bits come from the top of the word and their high bits from bit 0 upward.
- R6: Lanes never exchange bits. Changing data word k alters only output bytes 8k..8k+7.
- R7: A new operand pair is accepted on every cycle valid_i is high, with no bubbles and no lost or reordered results.
- R8: On a cycle when valid_i is low, result_o keeps its previous value whatever data_i and ctrl_i carry.
- R9: A control amount of 0 yields the word's bits [7:0], and an amount of 56 yields bits [63:56].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand pair valid |
| data_i | input | LANES*64 | Packed 64-bit data words, lane 0 in the low bits |
| ctrl_i | input | LANES*64 | Eight control bytes per lane, byte 0 lowest |
| valid_o | output | 1 | Result valid, one cycle after valid_i |
| result_o | output | LANES*64 | Extracted bytes, byte 8k+j from lane k |

## Verification
The bench goes after the wrap-around windows at amounts 57 to 63. A design that shifted instead of rotating would return zeros in the high bits of those bytes. It sets the top two control bits and compares against the same amount without them. A design that decoded seven or eight bits would select the wrong window or index past the word. It changes one lane's word alone to catch lane cross-wiring. It also runs back-to-back operands followed by idle gaps carrying junk inputs. Off-by-one latency shows up in that run as shifted or dropped results, and a missing hold shows up as results that change while valid_i is low.

// File: rtl/rot_field_pkg.sv
package rot_field_pkg;
  localparam int unsigned WORD_W   = 64;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned BYTES_PW = WORD_W / BYTE_W;
  localparam int unsigned SHAMT_W  = $clog2(WORD_W);

  typedef logic [WORD_W-1:0]  word_t;
  typedef logic [BYTE_W-1:0]  byte_t;
  typedef logic [SHAMT_W-1:0] shamt_t;
endpackage

// File: rtl/rot_byte_sel.sv
module rot_byte_sel
  import rot_field_pkg::*;
(
  input  word_t word_i,
  input  byte_t ctrl_i,
  output byte_t byte_o
);
  shamt_t amt;
  assign amt = ctrl_i[SHAMT_W-1:0];  // top control bits dropped

  always_comb begin
    for (int b = 0; b < BYTE_W; b++) begin
      shamt_t idx;
      idx       = amt + shamt_t'(b);  // wraps mod 64
      byte_o[b] = word_i[idx];
    end
  end

  always_comb begin
    // R9
    zero_shift_chk: assert (amt != '0 || byte_o == word_i[BYTE_W-1:0]);
    // R9
    top_byte_chk: assert (amt != shamt_t'(WORD_W - BYTE_W) || byte_o == word_i[WORD_W-1 -: BYTE_W]);
  end
endmodule

// File: rtl/rot_lane.sv
module rot_lane
  import rot_field_pkg::*;
(
  input  word_t                     word_i,
  input  logic [BYTES_PW*BYTE_W-1:0] ctrl_i,
  output logic [BYTES_PW*BYTE_W-1:0] bytes_o
);
  for (genvar j = 0; j < BYTES_PW; j++) begin : g_byte
    rot_byte_sel u_sel (
      .word_i (word_i),
      .ctrl_i (ctrl_i[j*BYTE_W +: BYTE_W]),
      .byte_o (bytes_o[j*BYTE_W +: BYTE_W])
    );
  end
endmodule

// File: rtl/rot_out_reg.sv
module rot_out_reg #(
  parameter int unsigned W = 512
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [W-1:0] d_i,
  output logic         valid_o,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      q_o     <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) q_o <= d_i;  // hold when idle
    end
  end
endmodule

// File: rtl/rot_field_extract.sv
module rot_field_extract
  import rot_field_pkg::*;
#(
  parameter int unsigned LANES = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic [LANES*WORD_W-1:0] data_i,
  input  logic [LANES*WORD_W-1:0] ctrl_i,
  output logic                    valid_o,
  output logic [LANES*WORD_W-1:0] result_o
);
  localparam int unsigned VEC_W = LANES * WORD_W;

  logic [VEC_W-1:0] extract_d;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    rot_lane u_lane (
      .word_i  (data_i[k*WORD_W +: WORD_W]),
      .ctrl_i  (ctrl_i[k*WORD_W +: WORD_W]),
      .bytes_o (extract_d[k*WORD_W +: WORD_W])
    );
  end

  rot_out_reg #(.W(VEC_W)) u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .d_i     (extract_d),
    .valid_o (valid_o),
    .q_o     (result_o)
  );

  // R2
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  // R2
  valid_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  // R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o));
  // R1
  reset_clear_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && result_o == '0));
endmodule

// File: tb/rot_field_extract_bench.sv
module rot_field_extract_bench;
  localparam int unsigned LANES = 8;
  localparam int unsigned VW    = LANES * 64;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0;
  logic [VW-1:0] data_i = '0;
  logic [VW-1:0] ctrl_i = '0;
  logic          valid_o;
  logic [VW-1:0] result_o;

  always #2.5 clk = ~clk;

  rot_field_extract #(.LANES(LANES)) u_rot_field_extract (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i),
    .data_i(data_i), .ctrl_i(ctrl_i), .valid_o(valid_o), .result_o(result_o)
  );

  typedef struct {
    logic [VW-1:0] exp;
    string         tag;
  } item_t;

  item_t         sb[$];
  int            checks = 0;
  int            fails  = 0;
  bit            done   = 0;
  bit            have_last = 0;
  logic [VW-1:0] last_res;

  function automatic logic [7:0] model_byte(logic [63:0] w, logic [7:0] c);
    logic [127:0] dbl;
    dbl = {w, w} >> c[5:0];
    return dbl[7:0];
  endfunction

  function automatic logic [VW-1:0] model(logic [VW-1:0] d, logic [VW-1:0] c);
    logic [VW-1:0] r;
    for (int k = 0; k < LANES; k++)
      for (int j = 0; j < 8; j++)
        r[64*k+8*j +: 8] = model_byte(d[64*k +: 64], c[64*k+8*j +: 8]);
    return r;
  endfunction

  task automatic check(string tag, logic [VW-1:0] act, logic [VW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic send(logic [VW-1:0] d, logic [VW-1:0] c, string tag);
    item_t it;
    @(negedge clk);
    valid_i = 1'b1;
    data_i  = d;
    ctrl_i  = c;
    it.exp  = model(d, c);
    it.tag  = tag;
    sb.push_back(it);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid_i = 1'b0;
      data_i  = {LANES{$urandom(), $urandom()}};
      ctrl_i  = {LANES{$urandom(), $urandom()}};
    end
  endtask

  function automatic logic [VW-1:0] mk_data(int seed);
    logic [VW-1:0] d;
    for (int k = 0; k < LANES; k++)
      d[64*k +: 64] = 64'h0123_4567_89AB_CDEF ^ (64'(seed + 1) * 64'h9E37_79B9_7F4A_7C15 + 64'(k) * 64'hC2B2_AE3D_27D4_EB4F);
    return d;
  endfunction

  function automatic logic [VW-1:0] mk_ctrl(int base, int step, logic [1:0] top);
    logic [VW-1:0] c;
    for (int k = 0; k < LANES; k++)
      for (int j = 0; j < 8; j++)
        c[64*k+8*j +: 8] = {top, 6'((base + step * j + k) % 64)};
    return c;
  endfunction

  // monitor
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      if (valid_o) begin
        if (sb.size() == 0) begin
          checks++; fails++;
          $display("FAIL R2 act=valid_o=1 exp=no pending item");
        end else begin
          item_t it;
          it = sb.pop_front();
          check(it.tag, result_o, it.exp);
        end
        last_res  = result_o;
        have_last = 1;
      end else if (have_last) begin
        check("R8 hold while idle", result_o, last_res);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [VW-1:0] d0, c0;
    repeat (3) @(negedge clk);
    // R1: during reset
    check("R1 reset valid", {{(VW-1){1'b0}}, valid_o}, '0);
    check("R1 reset result", result_o, '0);
    rst_ni = 1'b1;
    idle(2);
    check("R1 after release", {{(VW-1){1'b0}}, valid_o} | result_o, '0);

    // R9: amount 0 and 56
    send(mk_data(1), '0, "R9 amount 0 low byte");
    send(mk_data(2), {(VW/8){8'd56}}, "R9 amount 56 top byte");
    // R3: base64-style offsets and mixed amounts
    send(mk_data(3), mk_ctrl(0, 6, 2'b00), "R3 six-bit field offsets");
    send(mk_data(4), mk_ctrl(5, 13, 2'b00), "R3 mixed amounts");
    // R4: top control bits set; expect same as low six bits alone
    d0 = mk_data(5);
    c0 = mk_ctrl(9, 7, 2'b00);
    send(d0, mk_ctrl(9, 7, 2'b11), "R4 top bits ignored 11");
    send(d0, mk_ctrl(9, 7, 2'b10), "R4 top bits ignored 10");
    idle(1);
    // R5: wrap windows 57..63
    send(mk_data(6), mk_ctrl(57, 1, 2'b00), "R5 wrap 57-63");
    send({LANES{64'h8000_0000_0000_0001}}, {(VW/8){8'd63}}, "R5 wrap single bits");
    // R6: change lane 3 only
    send(mk_data(7), c0, "R6 base vector");
    d0 = mk_data(7);
    d0[3*64 +: 64] = ~d0[3*64 +: 64];
    send(d0, c0, "R6 lane 3 altered");
    idle(3);
    // R7: back-to-back stream
    for (int i = 0; i < 24; i++) begin
      logic [VW-1:0] rc;
      rc = {LANES{$urandom(), $urandom()}};
      send({LANES{$urandom(), $urandom()}}, rc, "R7 back-to-back");
    end
    // R8: gap with junk inputs
    idle(5);
    send(mk_data(8), mk_ctrl(3, 11, 2'b01), "R7 after gap");
    idle(4);
    // R2/R7: every result delivered
    checks++;
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL R7 act=%0d pending exp=0", sb.size());
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule